// File: doc/BRIEF.md
# DMA Burst Splitter

This block sits between a DMA engine and the command side of a system bus master. The DMA engine hands over one transfer at a time as a start address and a length in 32-bit words. The block cuts the transfer into bursts of a fixed, programmable number of beats and issues one burst command after another. Each command carries an address and a beat count. The block waits until every beat of a burst has been reported complete before it issues the next burst. When the last beat of the whole transfer completes, it pulses `done`.

Three plain control pins set the behaviour: a split enable, an 8-bit burst length, and a threshold enable with its threshold length. The block samples these only at the moment it accepts a request, so the configuration may change freely while a transfer is running. A registered flag reports a threshold setting that does not agree with the burst setting.

Both the request port and the command port are valid/ready. A source holds `req_valid` and the request fields steady until `req_ready` is seen. The block holds `cmd_valid`, `cmd_addr` and `cmd_beats` steady while `cmd_ready` is low. Completions come back as single-cycle `beat_done` pulses, which have no back-pressure.

Top module: `dma_burst_splitter`

## Requirements
- R1: `req_ready` is high only while no transfer is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `cmd_valid` and `req_ready` are never high together.
- R2: Splitting is in effect only when `cfg_split_en` is 1 and `cfg_burst_len` is non-zero. Otherwise the whole transfer goes out as one command whose beat count equals the request length.
- R3: With splitting in effect, every command carries `cfg_burst_len` beats, except the final one. The final command carries the length modulo the burst length whenever that remainder is non-zero.
- R4: The first command uses the request address. Each later command's address equals the previous command's address plus 4 times the previous beat count.
- R5: While `cmd_valid` is high and `cmd_ready` is low, the command fields do not change. One command is presented per burst, and the next command appears only after the previous burst has completed all its beats.
- R6: `beat_done` is counted only while an accepted burst is outstanding. A pulse that arrives while a command is still waiting for `cmd_ready` has no effect. A burst completes after exactly `cmd_beats` counted pulses.
- R7: `done` is high for exactly one cycle: the cycle after the edge that samples the last beat of the last burst. `req_ready` is high in that same cycle, so a new request can be accepted there.
- R8: A request of length 0 is accepted, produces no command, and raises `done` in the cycle after acceptance.
- R9: The split enable and burst length that are present at acceptance govern the whole transfer. Later changes to them have no effect until the next acceptance.
- R10: `cfg_err` is a register that, one cycle after its inputs, is high when `cfg_thr_en`, `cfg_split_en` and a non-zero `cfg_burst_len` are all set and the threshold length is either 0 or not a whole multiple of the burst length. Otherwise `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_split_en | input | 1 | Split enable |
| cfg_burst_len | input | BLEN_W | Beats per burst |
| cfg_thr_en | input | 1 | Threshold mode enable |
| cfg_thr_len | input | THR_W | Threshold length in words |
| cfg_err | output | 1 | Threshold/burst setting mismatch |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Transfer start byte address |
| req_words | input | LEN_W | Transfer length in 32-bit words |
| cmd_valid | output | 1 | Burst command valid |
| cmd_ready | input | 1 | Bus side takes the command |
| cmd_addr | output | ADDR_W | Burst start byte address |
| cmd_beats | output | LEN_W | Beats in this burst |
| beat_done | input | 1 | One beat of the current burst completed |
| done | output | 1 | Transfer finished pulse |

## Verification
Two things can happen in the same cycle: the `done` pulse of one transfer and the acceptance of the next request. The bench raises `req_valid` together with the final `beat_done` pulse. It then checks that `done` and `req_ready` are both high in the following cycle, and that the next transfer's first command appears one cycle later with the newly sampled configuration.

A second overlap is a `beat_done` pulse that lands while a command is still being held back by a low `cmd_ready`. The bench injects such a pulse on alternate bursts. It then checks that `done` stays low and no new command appears until every real beat has been delivered.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/dbs_cfg_check.sv
module dbs_cfg_check #(
  parameter int BLEN_W = 8,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_en,
  input  logic [BLEN_W-1:0] burst_len,
  input  logic              thr_en,
  input  logic [THR_W-1:0]  thr_len,
  output logic              cfg_err
);
  localparam int MW = (BLEN_W > THR_W) ? BLEN_W : THR_W;

  logic [MW-1:0] thr_w, blen_w, rem_w;
  logic          mismatch;

  always_comb begin
    thr_w  = MW'(thr_len);
    blen_w = MW'(burst_len);
    rem_w  = (blen_w == '0) ? '0 : (thr_w % blen_w);
    mismatch = thr_en && split_en && (blen_w != '0) &&
               ((thr_w == '0) || (rem_w != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= mismatch;
  end

  // R10
  err_needs_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($past(thr_en) && $past(split_en) && ($past(burst_len) != '0)));
endmodule

// File: rtl/dbs_beat_cnt.sv
module dbs_beat_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             beat_done,
  input  logic [LEN_W-1:0] beats,
  output logic             burst_end
);
  logic [LEN_W-1:0] cnt;

  assign burst_end = active && beat_done && (cnt == beats - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (start)              cnt <= '0;
    else if (active && beat_done) cnt <= cnt + LEN_W'(1);
  end

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < beats));
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_words,
  input  logic              split_en,
  input  logic [BLEN_W-1:0] burst_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_beats,
  input  logic              burst_end,
  output logic              cmd_fire,
  output logic              waiting,
  output logic              done
);
  seq_state_t       state;
  logic [LEN_W-1:0] size_q, rem_q;
  logic [ADDR_W-1:0] next_addr;
  logic [LEN_W-1:0] size_d;
  logic             eff_split;
  logic             accept;

  assign req_ready = (state == ST_IDLE);
  assign cmd_valid = (state == ST_ISSUE);
  assign waiting   = (state == ST_WAIT);
  assign accept    = req_valid && req_ready;
  assign cmd_fire  = cmd_valid && cmd_ready;

  always_comb begin
    eff_split = split_en && (burst_len != '0);
    size_d    = eff_split ? LEN_W'(burst_len) : req_words;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      size_q    <= '0;
      rem_q     <= '0;
      cmd_addr  <= '0;
      cmd_beats <= '0;
      next_addr <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          size_q   <= size_d;
          rem_q    <= req_words;
          cmd_addr <= req_addr;
          if (req_words == '0) begin
            done <= 1'b1;
          end else begin
            cmd_beats <= (req_words < size_d) ? req_words : size_d;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (cmd_ready) begin
          rem_q     <= rem_q - cmd_beats;
          next_addr <= cmd_addr + ADDR_W'({cmd_beats, 2'b00});
          state     <= ST_WAIT;
        end
        ST_WAIT: if (burst_end) begin
          if (rem_q == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cmd_addr  <= next_addr;
            cmd_beats <= (rem_q < size_q) ? rem_q : size_q;
            state     <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Shadow of the previous command end, kept for the address checks
  logic [ADDR_W-1:0] shadow_end;
  logic              shadow_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_end <= '0;
      shadow_ok  <= 1'b0;
    end else if (accept) begin
      shadow_ok <= 1'b0;
    end else if (cmd_fire) begin
      shadow_end <= cmd_addr + ADDR_W'(cmd_beats) * ADDR_W'(4);
      shadow_ok  <= 1'b1;
    end
  end

  // R1
  ready_vs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && cmd_valid));
  // R4
  addr_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && shadow_ok) |-> (cmd_addr == shadow_end));
  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_beats)));
  // R3
  beats_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_beats != '0) && (cmd_beats <= size_q)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BLEN_W = 8,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_split_en,
  input  logic [BLEN_W-1:0] cfg_burst_len,
  input  logic              cfg_thr_en,
  input  logic [THR_W-1:0]  cfg_thr_len,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_words,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_beats,
  input  logic              beat_done,
  output logic              done
);
  logic cmd_fire, waiting, burst_end;

  dbs_cfg_check #(.BLEN_W(BLEN_W), .THR_W(THR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .split_en(cfg_split_en), .burst_len(cfg_burst_len),
    .thr_en(cfg_thr_en), .thr_len(cfg_thr_len), .cfg_err(cfg_err)
  );

  dbs_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLEN_W(BLEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_words(req_words), .split_en(cfg_split_en),
    .burst_len(cfg_burst_len), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .burst_end(burst_end),
    .cmd_fire(cmd_fire), .waiting(waiting), .done(done)
  );

  dbs_beat_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(cmd_fire), .active(waiting),
    .beat_done(beat_done), .beats(cmd_beats), .burst_end(burst_end)
  );

  // R6
  no_cmd_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !cmd_valid);
endmodule

// File: tb/dma_burst_splitter_test.sv
module dma_burst_splitter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_split_en = 1'b0;
  logic [7:0]  cfg_burst_len = '0;
  logic        cfg_thr_en = 1'b0;
  logic [7:0]  cfg_thr_len = '0;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_words = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_beats;
  logic        beat_done = 1'b0;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cur_en;
  int cur_blen;

  always #10 clk = ~clk;

  dma_burst_splitter uut (
    .clk(clk), .rst_n(rst_n), .cfg_split_en(cfg_split_en), .cfg_burst_len(cfg_burst_len),
    .cfg_thr_en(cfg_thr_en), .cfg_thr_len(cfg_thr_len), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_words(req_words),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_beats(cmd_beats),
    .beat_done(beat_done), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Apply the R9 disturbance: scramble the configuration after acceptance
  task automatic scramble();
    cfg_split_en  = ~cur_en;
    cfg_burst_len = 8'(cur_blen + 3);
  endtask

  task automatic start_req(input logic [31:0] a, input int words);
    cfg_split_en  = cur_en;
    cfg_burst_len = 8'(cur_blen);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_words = 16'(words);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    scramble();
  endtask

  // Called at the negedge after acceptance; serves all bursts and checks done
  task automatic serve(input logic [31:0] a, input int words, input bit chain,
                       input logic [31:0] na, input int nw);
    int size, rem, k, nb;
    logic [31:0] ea;
    size = (cur_en && cur_blen != 0) ? cur_blen : words;
    rem = words; ea = a; k = 0;
    if (words == 0) begin
      check(done == 1'b1, "R8 zero-length done", done, 1);
      check(cmd_valid == 1'b0, "R8 no command", cmd_valid, 0);
      @(negedge clk);
      check(done == 1'b0, "R7 done single cycle", done, 0);
      return;
    end
    while (rem > 0) begin
      nb = (rem < size) ? rem : size;
      check(cmd_valid == 1'b1, "R5 command presented", cmd_valid, 1);
      check(cmd_addr == ea, "R4 burst address", cmd_addr, ea);
      check(cmd_beats == 16'(nb), "R3 beat count", cmd_beats, nb);
      if (k % 2 == 1) begin
        beat_done = 1'b1;
        @(negedge clk);
        beat_done = 1'b0;
        check(cmd_valid && cmd_addr == ea && cmd_beats == 16'(nb), "R5 held under back-pressure",
              cmd_beats, nb);
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      for (int b = 0; b < nb; b++) begin
        if (b % 3 == 2) @(negedge clk);
        beat_done = 1'b1;
        if (chain && rem == nb && b == nb - 1) begin
          cfg_split_en = cur_en; cfg_burst_len = 8'(cur_blen);
          req_valid = 1'b1; req_addr = na; req_words = 16'(nw);
        end
        @(negedge clk);
        beat_done = 1'b0;
        if (b < nb - 1)
          check(!cmd_valid && !done, "R6 burst not finished early", done, 0);
      end
      rem -= nb; ea = ea + 32'(4 * nb); k++;
      if (rem > 0)
        check(done == 1'b0, "R7 no done between bursts", done, 0);
    end
    check(done == 1'b1, "R7 done after last beat", done, 1);
    check(req_ready == 1'b1, "R7 ready with done", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    if (chain) begin
      req_valid = 1'b0;
      scramble();
    end
    check(done == 1'b0, "R7 done single cycle", done, 0);
  endtask

  initial begin
    int blens[6] = '{0, 1, 2, 3, 5, 8};
    bit exp_err;
    #45;
    check(req_ready == 1'b0 || req_ready == 1'b1, "R1 reset", 0, 0);
    check(cmd_valid == 1'b0 && done == 1'b0 && cfg_err == 1'b0, "R1 reset outputs", cmd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 idle after reset", req_ready, 1);

    // R2 R3 R4 R9: sweep enable, burst length and transfer length
    for (int e = 0; e < 2; e++)
      for (int bi = 0; bi < 6; bi++)
        for (int w = 0; w < 10; w++) begin
          cur_en = e[0]; cur_blen = blens[bi];
          start_req(32'h1000 + 32'(w * 64) + 32'(bi * 4), w);
          serve(32'h1000 + 32'(w * 64) + 32'(bi * 4), w, 1'b0, '0, 0);
        end

    // R7 R1: next request accepted in the done cycle
    cur_en = 1'b1; cur_blen = 3;
    start_req(32'h2000, 7);
    serve(32'h2000, 7, 1'b1, 32'h3000, 5);
    serve(32'h3000, 5, 1'b0, '0, 0);

    // R10: legality flag sweep
    cfg_thr_en = 1'b1;
    for (int e = 0; e < 2; e++)
      for (int bl = 0; bl <= 8; bl++)
        for (int th = 0; th <= 16; th++) begin
          @(negedge clk);
          cfg_split_en = e[0]; cfg_burst_len = 8'(bl); cfg_thr_len = 8'(th);
          @(negedge clk);
          exp_err = e[0] && bl != 0 && (th == 0 || th % bl != 0);
          check(cfg_err == exp_err, "R10 legality flag", cfg_err, exp_err);
        end
    @(negedge clk);
    cfg_thr_en = 1'b0; cfg_split_en = 1'b1; cfg_burst_len = 8'd3; cfg_thr_len = 8'd4;
    @(negedge clk);
    check(cfg_err == 1'b0, "R10 threshold off", cfg_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule